// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits between the byte-write interface of a paged non-volatile memory and its page-load logic. It examines every completed byte write (a 15-bit address and 8 bits of data). It decides whether the write goes on to the array, is held back because it may belong to a command sequence, or is thrown away. It also keeps the protection flag. The flag is clear after reset. A three-write unlock prefix followed by a real data write sets it. A six-write release sequence clears it.

While the flag is clear, ordinary writes pass through. A write that could be the start or middle of a command sequence is held in a small queue. If the sequence is broken, the held writes are released in their arrival order, followed by the write that broke the sequence. If the sequence completes, the held writes are dropped. While the flag is set, a data write reaches the array only when the unlock prefix comes right before it, and command bytes are never written. Commits leave on `cmt_valid`, one per cycle. The source of write events must leave at least eight cycles between events so that a full release can drain.

Top module: `sdp_guard`

## Requirements
- R1: After reset, `prot_on` is 0 and `cmt_valid` is 0.
- R2: With protection off, a write that cannot begin a command (anything other than data 0xAA at address 0x5555) produces exactly one commit with the same address and data, with `cmt_valid` high in the cycle after the event edge.
- R3: The unlock prefix is data 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. The next write after it, whatever its value, is committed alone and sets `prot_on`. The three prefix writes are never committed. The prefix by itself leaves `prot_on` unchanged.
- R4: With protection on, a write that is not preceded by the unlock prefix is discarded: no commit, and `prot_on` stays 1.
- R5: With protection on, the unlock prefix followed by a data write commits that write alone, and `prot_on` stays 1.
- R6: The release sequence is data 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. It clears `prot_on` and commits none of its six writes, whichever mode it starts from.
- R7: With protection off, when a write does not match the next expected step, the held writes and then the breaking write are committed in arrival order on consecutive cycles, starting the cycle after the breaking event. The detector then returns to idle.
- R8: With protection on, a mismatching write abandons the sequence and nothing is committed. A later data write is then discarded unless a full prefix comes before it again.
- R9: Matching compares all 15 address bits and all 8 data bits exactly. A code write with one address bit wrong counts as a mismatch.
- R10: `prot_on` changes only in the cycle after a completing unlock-plus-data or release event. `cmt_valid` pulses form one unbroken run per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle pulse: a byte write has completed |
| wr_addr | input | ADDR_W (15) | Address of the completed write |
| wr_data | input | DATA_W (8) | Data of the completed write |
| cmt_valid | output | 1 | Write permitted to the page-load logic this cycle |
| cmt_addr | output | ADDR_W (15) | Address of the permitted write |
| cmt_data | output | DATA_W (8) | Data of the permitted write |
| prot_on | output | 1 | Protection flag |

## Verification
Every result follows from the event edge. `prot_on` settles one edge after the completing write. The first commit of any event is valid in the cycle right after the event edge, and a release of n held writes fills n+1 consecutive cycles. The bench drives each event at a falling edge. It then samples `cmt_valid` at the next ten falling edges and records the sample index of every commit. From that record it checks that the first commit lands at index 0 and that the later ones follow without gaps. `prot_on` is read only after that window, so a flag change is seen exactly one edge after its cause and no sample races a clock edge.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int CODE_AW = 15;
  localparam int CODE_DW = 8;

  localparam logic [CODE_AW-1:0] ADR_HI = 15'h5555;
  localparam logic [CODE_AW-1:0] ADR_LO = 15'h2AAA;

  localparam logic [CODE_DW-1:0] D_LEAD   = 8'hAA;
  localparam logic [CODE_DW-1:0] D_SECOND = 8'h55;
  localparam logic [CODE_DW-1:0] D_UNLOCK = 8'hA0;
  localparam logic [CODE_DW-1:0] D_RELPRE = 8'h80;
  localparam logic [CODE_DW-1:0] D_RELFIN = 8'h20;

  // longest run of held writes plus the breaking write
  localparam int RELEASE_LEN = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_ARMED, ST_D3, ST_D4, ST_D5
  } seq_state_t;

  typedef enum logic [2:0] {
    ACT_NONE,   // nothing to the queue
    ACT_HOLD,   // append this write to the held list
    ACT_FLUSH,  // release held list followed by this write
    ACT_SOLO,   // drop held list, commit only this write
    ACT_CLEAR   // drop held list, commit nothing
  } act_t;

  function automatic logic code_hit(input logic [CODE_AW-1:0] a,
                                    input logic [CODE_DW-1:0] d,
                                    input logic [CODE_AW-1:0] ea,
                                    input logic [CODE_DW-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // in protected mode nothing is ever held: hold becomes none, flush becomes clear
  function automatic act_t mode_filter(input act_t a, input logic prot);
    if (!prot) return a;
    case (a)
      ACT_HOLD:  return ACT_NONE;
      ACT_FLUSH: return ACT_CLEAR;
      default:   return a;
    endcase
  endfunction
endpackage

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev,
  input  logic [CODE_AW-1:0] addr,
  input  logic [CODE_DW-1:0] data,
  output act_t               act,
  output logic               prot_on,
  output logic               set_evt,
  output logic               clr_evt
);
  seq_state_t st_q, st_d;
  act_t       raw_act;
  logic       prot_q;

  always_comb begin
    st_d    = st_q;
    raw_act = ACT_NONE;
    set_evt = 1'b0;
    clr_evt = 1'b0;
    if (ev) begin
      st_d    = ST_IDLE;
      raw_act = ACT_FLUSH;
      case (st_q)
        ST_IDLE:  if (code_hit(addr, data, ADR_HI, D_LEAD))   begin st_d = ST_K1; raw_act = ACT_HOLD; end
        ST_K1:    if (code_hit(addr, data, ADR_LO, D_SECOND)) begin st_d = ST_K2; raw_act = ACT_HOLD; end
        ST_K2: begin
          if (code_hit(addr, data, ADR_HI, D_UNLOCK)) begin
            st_d = ST_ARMED; raw_act = ACT_HOLD;
          end else if (code_hit(addr, data, ADR_HI, D_RELPRE)) begin
            st_d = ST_D3; raw_act = ACT_HOLD;
          end
        end
        ST_ARMED: begin
          raw_act = ACT_SOLO;
          set_evt = 1'b1;
        end
        ST_D3:    if (code_hit(addr, data, ADR_HI, D_LEAD))   begin st_d = ST_D4; raw_act = ACT_HOLD; end
        ST_D4:    if (code_hit(addr, data, ADR_LO, D_SECOND)) begin st_d = ST_D5; raw_act = ACT_HOLD; end
        ST_D5: if (code_hit(addr, data, ADR_HI, D_RELFIN)) begin
          raw_act = ACT_CLEAR;
          clr_evt = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign act     = mode_filter(raw_act, prot_q);
  assign prot_on = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prot_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (set_evt)      prot_q <= 1'b1;
      else if (clr_evt) prot_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdp_hold_queue.sv
module sdp_hold_queue
  import sdp_pkg::*;
#(
  parameter int AW    = 15,
  parameter int DW    = 8,
  parameter int DEPTH = RELEASE_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_t          act,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          cmt_valid,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data,
  output logic          draining
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] buf_a [DEPTH];
  logic [DW-1:0] buf_d [DEPTH];
  logic [CW-1:0] pend_q, left_q, idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      left_q <= '0;
      idx_q  <= '0;
    end else begin
      if (left_q != '0) begin
        left_q <= left_q - CW'(1);
        idx_q  <= idx_q + CW'(1);
      end
      case (act)
        ACT_HOLD: pend_q <= pend_q + CW'(1);
        ACT_FLUSH: begin
          left_q <= pend_q + CW'(1);
          idx_q  <= '0;
          pend_q <= '0;
        end
        ACT_SOLO: begin
          left_q <= CW'(1);
          idx_q  <= '0;
          pend_q <= '0;
        end
        ACT_CLEAR: pend_q <= '0;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic wr_here;
      assign wr_here = ((act == ACT_HOLD || act == ACT_FLUSH) && pend_q == CW'(g))
                    || (act == ACT_SOLO && g == 0);
      always_ff @(posedge clk) begin
        if (wr_here) begin
          buf_a[g] <= in_addr;
          buf_d[g] <= in_data;
        end
      end
    end
  endgenerate

  assign draining  = (left_q != '0);
  assign cmt_valid = draining;
  assign cmt_addr  = buf_a[idx_q];
  assign cmt_data  = buf_d[idx_q];
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmt_valid,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic              prot_on
);
  act_t act;
  logic set_evt, clr_evt, solo_evt, draining;

  sdp_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (wr_valid),
    .addr    (wr_addr[CODE_AW-1:0]),
    .data    (wr_data[CODE_DW-1:0]),
    .act     (act),
    .prot_on (prot_on),
    .set_evt (set_evt),
    .clr_evt (clr_evt)
  );

  sdp_hold_queue #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(RELEASE_LEN)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .cmt_valid (cmt_valid),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .draining  (draining)
  );

  assign solo_evt = (act == ACT_SOLO);
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic cmt_valid,
  input logic prot_on,
  input logic set_evt,
  input logic clr_evt,
  input logic solo_evt,
  input logic draining
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !cmt_valid && !prot_on);

  // R10
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $rose(prot_on) |-> $past(set_evt));

  // R6
  prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $fell(prot_on) |-> $past(clr_evt));

  // R4
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && prot_on && !solo_evt |=> !cmt_valid);

  // R7
  run_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && cmt_valid && !$past(wr_valid) |-> $past(cmt_valid));

  // R10
  no_event_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !draining);
endmodule

bind sdp_guard sdp_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .cmt_valid (cmt_valid),
  .prot_on   (prot_on),
  .set_evt   (set_evt),
  .clr_evt   (clr_evt),
  .solo_evt  (solo_evt),
  .draining  (draining)
);

// File: tb/sdp_guard_tb.sv
module sdp_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cmt_valid;
  logic [14:0] cmt_addr;
  logic [7:0]  cmt_data;
  logic        prot_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [14:0] got_a [8];
  logic [7:0]  got_d [8];
  int          got_c [8];
  int          got_n;
  logic [14:0] exp_a [8];
  logic [7:0]  exp_d [8];

  always #2 clk = ~clk;

  sdp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .prot_on(prot_on)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    got_n = 0;
    for (int i = 0; i < 10; i++) begin
      if (i > 0) @(negedge clk);
      if (cmt_valid) begin
        if (got_n < 8) begin
          got_a[got_n] = cmt_addr; got_d[got_n] = cmt_data; got_c[got_n] = i;
        end
        got_n++;
      end
    end
  endtask

  task automatic exp_set(input int i, input logic [14:0] a, input logic [7:0] d);
    exp_a[i] = a; exp_d[i] = d;
  endtask

  // compares the recorded commits against exp_*[0..n-1]; commit i must sit at sample i
  task automatic check_got(input string tag, input int n);
    chk(got_n == n, {tag, " commit count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      chk(got_a[i] == exp_a[i] && got_d[i] == exp_d[i] && got_c[i] == i,
          {tag, " commit content/slot"}, {got_c[i][7:0], got_a[i], got_d[i]},
          {i[7:0], exp_a[i], exp_d[i]});
  endtask

  task automatic chk_prot(input string tag, input logic e);
    chk(prot_on == e, {tag, " prot_on"}, prot_on, e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic prefix(input string tag);
    send(15'h5555, 8'hAA); check_got(tag, 0);
    send(15'h2AAA, 8'h55); check_got(tag, 0);
    send(15'h5555, 8'hA0); check_got(tag, 0);
  endtask

  task automatic release_seq(input string tag);
    send(15'h5555, 8'hAA); check_got(tag, 0);
    send(15'h2AAA, 8'h55); check_got(tag, 0);
    send(15'h5555, 8'h80); check_got(tag, 0);
    send(15'h5555, 8'hAA); check_got(tag, 0);
    send(15'h2AAA, 8'h55); check_got(tag, 0);
    send(15'h5555, 8'h20); check_got(tag, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_prot("R1", 1'b0);
    chk(cmt_valid == 1'b0, "R1 cmt_valid", cmt_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_plain();
    send(15'h1234, 8'h5A); exp_set(0, 15'h1234, 8'h5A); check_got("R2", 1);
    send(15'h5555, 8'h55); exp_set(0, 15'h5555, 8'h55); check_got("R2 near-code", 1);
    chk_prot("R2", 1'b0);
  endtask

  task automatic t_break_unprot();
    send(15'h5555, 8'hAA); check_got("R7", 0);
    send(15'h2AAA, 8'h55); check_got("R7", 0);
    send(15'h0100, 8'h11);
    exp_set(0, 15'h5555, 8'hAA); exp_set(1, 15'h2AAA, 8'h55); exp_set(2, 15'h0100, 8'h11);
    check_got("R7 three", 3);
    chk_prot("R7", 1'b0);
  endtask

  task automatic t_addr_exact();
    send(15'h5555, 8'hAA); send(15'h2AAA, 8'h55);
    send(15'h5554, 8'hA0);
    exp_set(0, 15'h5555, 8'hAA); exp_set(1, 15'h2AAA, 8'h55); exp_set(2, 15'h5554, 8'hA0);
    check_got("R9 addr bit", 3);
    chk_prot("R9", 1'b0);
  endtask

  task automatic t_enable();
    prefix("R3 prefix");
    chk_prot("R3 prefix alone", 1'b0);
    send(15'h0200, 8'h77); exp_set(0, 15'h0200, 8'h77); check_got("R3 data", 1);
    chk_prot("R3 set", 1'b1);
  endtask

  task automatic t_prot_plain();
    send(15'h0300, 8'h33); check_got("R4", 0);
    chk_prot("R4", 1'b1);
  endtask

  task automatic t_prot_write();
    prefix("R5 prefix");
    send(15'h0400, 8'h44); exp_set(0, 15'h0400, 8'h44); check_got("R5", 1);
    chk_prot("R5", 1'b1);
    send(15'h0401, 8'h45); check_got("R5 prefix per write", 0);
  endtask

  task automatic t_prot_break();
    send(15'h5555, 8'hAA); send(15'h2AAB, 8'h55); check_got("R8 R9", 0);
    send(15'h0500, 8'h66); check_got("R8 after break", 0);
    chk_prot("R8", 1'b1);
  endtask

  task automatic t_disable_prot();
    release_seq("R6 prot");
    chk_prot("R6 cleared", 1'b0);
  endtask

  task automatic t_disable_unprot();
    release_seq("R6 unprot");
    chk_prot("R6 stays off", 1'b0);
    send(15'h0600, 8'h01); exp_set(0, 15'h0600, 8'h01); check_got("R6 after", 1);
  endtask

  task automatic t_break_long();
    send(15'h5555, 8'hAA); send(15'h2AAA, 8'h55); send(15'h5555, 8'h80);
    send(15'h5555, 8'hAA); send(15'h2AAA, 8'h55);
    send(15'h5555, 8'h21);
    exp_set(0, 15'h5555, 8'hAA); exp_set(1, 15'h2AAA, 8'h55); exp_set(2, 15'h5555, 8'h80);
    exp_set(3, 15'h5555, 8'hAA); exp_set(4, 15'h2AAA, 8'h55); exp_set(5, 15'h5555, 8'h21);
    check_got("R7 six", 6);
    chk_prot("R10", 1'b0);
  endtask

  task automatic t_reset_prot();
    prefix("R1 re-arm");
    send(15'h0700, 8'h99); exp_set(0, 15'h0700, 8'h99); check_got("R3 re-arm", 1);
    chk_prot("R3 re-arm", 1'b1);
    do_reset();
    @(negedge clk);
    chk_prot("R1 after reset", 1'b0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_break_unprot();
    t_addr_exact();
    t_enable();
    t_prot_plain();
    t_prot_write();
    t_prot_break();
    t_disable_prot();
    t_disable_unprot();
    t_break_long();
    t_reset_prot();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule